// File: doc/BRIEF.md
# Independent watchdog timer

This block is a watchdog that keeps time from its own slow clock, independent of the bus clock. A prescaler divides that clock, and each divided tick decrements a 12-bit counter. Software has to refresh the counter before it runs out. If a tick arrives while the counter is already zero, the block drives a reset pulse for a fixed number of watchdog-clock cycles and reloads the counter. The counter value is also an output, so the block can serve as a free-running timeout timer.

Software writes through a single bus-clock port. A write goes into a holding register and is carried into the watchdog domain by a toggle handshake, and a busy flag stays high until the update has landed. Writes to the key address start the watchdog, refresh it, or open write access to the divider and reload registers. Once started, the watchdog cannot be stopped. A hardware option input can start it straight out of reset. A debug-halt input freezes both the prescaler and the counter.

Top module: `indep_watchdog`

## Requirements
- R1: After reset the count output is 0xFFF, active is 0, wdg_rst is 0 and busy is 0. The reload value is 0xFFF and the divider code is 0.
- R2: While active is 1 and dbg_halt is 0, count decreases by one every 4<<code watchdog-clock cycles, where code is 0 to 6. Code 7 divides by 256, the same as code 6.
- R3: A prescaler tick that arrives while count is 0 makes wdg_rst high for RST_CYCLES watchdog-clock cycles and loads count from the reload value.
- R4: Writing 0xCCCC to address 0 sets active, loads count from the reload value and clears the prescaler phase. While active is 0, count does not change. Once active is 1, no write or key value clears it.
- R5: Writing 0xAAAA to address 0 loads count from the reload value and clears the prescaler phase, whether or not the counter is halted.
- R6: Writing 0x5555 to address 0 enables writes to address 1 (divider code, data bits 2:0) and address 2 (reload value, data bits 11:0). Any other write to address 0 disables them again. While disabled, writes to addresses 1 and 2 have no effect. Address 3 is ignored.
- R7: When hw_start is 1, active becomes 1 at the first watchdog-clock edge after reset, with no key write.
- R8: While dbg_halt is 1, neither the prescaler nor count advances.
- R9: An accepted write raises busy on the next bus-clock edge. busy falls once the update has been applied in the watchdog domain and the acknowledge has come back. A write presented while busy is 1 is dropped.
- R10: An accepted write takes effect at the third rising edge of the watchdog clock after the bus-clock edge that accepted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0 key, 1 divider code, 2 reload value |
| wr_data | input | 16 | Write data |
| busy | output | 1 | An update is still crossing into the watchdog domain |
| wclk | input | 1 | Independent watchdog clock |
| hw_start | input | 1 | Hardware option that starts the watchdog after reset |
| dbg_halt | input | 1 | Freezes counting while high |
| wdg_rst | output | 1 | Reset pulse on expiry |
| count | output | 12 | Current counter value |
| active | output | 1 | Watchdog running |

## Verification
A wrong prescaler phase or divider decode shows on count within one divided period: it changes a cycle too early or too late. A corrupted reload or unlock state shows up as a wrong count in the cycle a refresh is applied. An error in the crossing shifts that same step by whole watchdog-clock cycles, or leaves busy stuck high. The bench's reference model compares count, active and wdg_rst after every watchdog-clock edge, so any drift is caught in the cycle it first appears.

// File: rtl/indep_watchdog.sv
module indep_watchdog #(
  parameter int CNT_W      = 12,
  parameter int PRE_W      = 8,
  parameter int SEL_W      = 3,
  parameter int RST_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [15:0]      wr_data,
  output logic             busy,
  input  logic             wclk,
  input  logic             hw_start,
  input  logic             dbg_halt,
  output logic             wdg_rst,
  output logic [CNT_W-1:0] count,
  output logic             active
);
  localparam int MAX_SH = PRE_W - 2;
  localparam int RC_W   = $clog2(RST_CYCLES + 1);
  localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [15:0] KEY_START   = 16'hCCCC;
  localparam logic [15:0] KEY_UNLOCK  = 16'h5555;

  logic        req, ack1, ack2;
  logic [1:0]  hold_addr;
  logic [15:0] hold_data;
  logic        s1, s2, s3, pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0; ack1 <= 1'b0; ack2 <= 1'b0;
      hold_addr <= '0; hold_data <= '0;
    end else begin
      ack1 <= s3;
      ack2 <= ack1;
      if (wr_en && !busy) begin
        req       <= ~req;
        hold_addr <= wr_addr;
        hold_data <= wr_data;
      end
    end
  end

  assign busy = req ^ ack2;
  assign pend = s2 ^ s3;

  logic [SEL_W-1:0] psel;
  logic [CNT_W-1:0] rld, cnt;
  logic [PRE_W-1:0] pcnt, pre_lim;
  logic [PRE_W:0]   div_full;
  logic [RC_W-1:0]  rcnt;
  logic             run, unl, tick, fire;
  int               sh;

  always_comb begin
    sh       = (int'(psel) > MAX_SH) ? MAX_SH : int'(psel);
    div_full = (PRE_W+1)'(1) << (sh + 2);
    pre_lim  = PRE_W'(div_full - 1'b1);
  end

  assign tick = run && !dbg_halt && (pcnt >= pre_lim);
  assign fire = tick && (cnt == '0);

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      run <= 1'b0; unl <= 1'b0;
      psel <= '0; rld <= '1; cnt <= '1; pcnt <= '0; rcnt <= '0;
    end else begin
      s1 <= req; s2 <= s1; s3 <= s2;
      if (hw_start) run <= 1'b1;
      if (run && !dbg_halt) begin
        pcnt <= tick ? '0 : pcnt + 1'b1;
        if (tick) cnt <= (cnt == '0) ? rld : cnt - 1'b1;
      end
      if (fire)              rcnt <= RC_W'(RST_CYCLES);
      else if (rcnt != '0)   rcnt <= rcnt - 1'b1;
      if (pend) begin
        case (hold_addr)
          2'd0: begin
            unl <= (hold_data == KEY_UNLOCK);
            if (hold_data == KEY_REFRESH || hold_data == KEY_START) begin
              cnt  <= rld;
              pcnt <= '0;
            end
            if (hold_data == KEY_START) run <= 1'b1;
          end
          2'd1: if (unl) psel <= hold_data[SEL_W-1:0];
          2'd2: if (unl) rld  <= hold_data[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign wdg_rst = (rcnt != '0);
  assign count   = cnt;
  assign active  = run;
endmodule

// File: rtl/indep_watchdog_props.sv
module indep_watchdog_props #(
  parameter int CNT_W      = 12,
  parameter int RST_CYCLES = 3
) (
  input logic             clk,
  input logic             wclk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             busy,
  input logic [1:0]       hold_addr,
  input logic [15:0]      hold_data,
  input logic             pend,
  input logic             dbg_halt,
  input logic             active,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] rld,
  input logic             wdg_rst
);
  logic [15:0] hi_len;
  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) hi_len <= '0;
    else        hi_len <= wdg_rst ? hi_len + 1'b1 : '0;

  assert_pulse_len_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    $fell(wdg_rst) |-> hi_len == 16'(RST_CYCLES));

  assert_one_step_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    (active && !pend && count != '0) |=> (count == $past(count) || count == $past(count) - 1'b1));

  assert_idle_still_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    (!active && !pend) |=> $stable(count));

  assert_no_stop_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    active |=> active);

  assert_refresh_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    (pend && hold_addr == 2'd0 && hold_data == 16'hAAAA) |=> count == $past(rld));

  assert_halt_freeze_R8: assert property (@(posedge wclk) disable iff (!rst_n)
    (dbg_halt && !pend) |=> $stable(count));

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> ($stable(hold_addr) && $stable(hold_data)));
endmodule

bind indep_watchdog indep_watchdog_props #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_props (
  .clk(clk), .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
  .hold_addr(hold_addr), .hold_data(hold_data), .pend(pend), .dbg_halt(dbg_halt),
  .active(active), .count(count), .rld(rld), .wdg_rst(wdg_rst)
);

// File: tb/tb_indep_watchdog.sv
`timescale 1ns/1ps
module tb_indep_watchdog;
  localparam int RSTC = 3;

  logic clk = 0, wclk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic hw_start = 0, dbg_halt = 0;
  logic busy, wdg_rst, active;
  logic [11:0] count;

  indep_watchdog #(.RST_CYCLES(RSTC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .wclk(wclk), .hw_start(hw_start), .dbg_halt(dbg_halt),
    .wdg_rst(wdg_rst), .count(count), .active(active));

  always #4 clk = ~clk;
  initial begin #2; forever #20 wclk = ~wclk; end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  int wpos = 0;
  bit h_s, d_s, r_s;
  always @(posedge wclk) begin
    wpos++;
    h_s = hw_start; d_s = dbg_halt; r_s = rst_n;
  end

  int q_at[$];
  int q_ad[$];
  int q_dt[$];
  int m_cnt = 'hFFF, m_pc = 0, m_run = 0, m_unl = 0, m_psel = 0, m_rld = 'hFFF, m_rc = 0;
  int n_cnt, n_pc, n_run, n_unl, n_psel, n_rld, n_rc, lim, ad, dt;
  bit tk;

  always @(negedge wclk) begin
    if (!rst_n) begin
      m_cnt = 'hFFF; m_pc = 0; m_run = 0; m_unl = 0; m_psel = 0; m_rld = 'hFFF; m_rc = 0;
      q_at.delete(); q_ad.delete(); q_dt.delete();
    end else if (r_s) begin
      lim = (4 << ((m_psel > 6) ? 6 : m_psel)) - 1;
      tk = m_run != 0 && !d_s && m_pc >= lim;
      n_cnt = m_cnt; n_pc = m_pc; n_run = m_run | int'(h_s); n_unl = m_unl;
      n_psel = m_psel; n_rld = m_rld;
      if (m_run != 0 && !d_s) begin
        n_pc = tk ? 0 : m_pc + 1;
        if (tk) n_cnt = (m_cnt == 0) ? m_rld : m_cnt - 1;
      end
      if (tk && m_cnt == 0) n_rc = RSTC;
      else n_rc = (m_rc > 0) ? m_rc - 1 : 0;
      if (q_at.size() > 0 && q_at[0] == wpos) begin
        ad = q_ad.pop_front(); dt = q_dt.pop_front(); void'(q_at.pop_front());
        if (ad == 0) begin
          n_unl = (dt == 'h5555);
          if (dt == 'hAAAA || dt == 'hCCCC) begin n_cnt = m_rld; n_pc = 0; end
          if (dt == 'hCCCC) n_run = 1;
        end else if (ad == 1) begin
          if (m_unl != 0) n_psel = dt & 7;
        end else if (ad == 2) begin
          if (m_unl != 0) n_rld = dt & 'hFFF;
        end
      end
      m_cnt = n_cnt; m_pc = n_pc; m_run = n_run; m_unl = n_unl;
      m_psel = n_psel; m_rld = n_rld; m_rc = n_rc;
      chk(int'(count) == m_cnt, "count R2 R5 R10", int'(count), m_cnt);
      chk(int'(wdg_rst) == int'(m_rc != 0), "wdg_rst R3", int'(wdg_rst), int'(m_rc != 0));
      chk(int'(active) == m_run, "active R4 R7", int'(active), m_run);
    end
  end

  task automatic waitw(input int n);
    repeat (n) @(negedge wclk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input bit wait_done, output bit acc);
    @(negedge clk);
    acc = !busy;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
    if (acc) begin
      q_at.push_back(wpos + 3); q_ad.push_back(int'(a)); q_dt.push_back(int'(d));
      chk(busy == 1'b1, "busy rise R9", int'(busy), 1);
    end
    if (wait_done) begin
      for (int i = 0; i < 100; i++) begin
        if (!busy) break;
        @(negedge clk);
      end
      chk(busy == 1'b0, "busy clear R9", int'(busy), 0);
      waitw(1);
    end
  endtask

  bit acc;
  int c0, seen;

  initial begin
    #99 rst_n = 1;
    waitw(1);
    chk(count == 12'hFFF, "reset count R1", int'(count), 'hFFF);
    chk(active == 1'b0, "reset active R1", int'(active), 0);
    chk(wdg_rst == 1'b0, "reset wdg_rst R1", int'(wdg_rst), 0);
    chk(busy == 1'b0, "reset busy R1", int'(busy), 0);
    waitw(10);
    chk(count == 12'hFFF, "idle count R4", int'(count), 'hFFF);

    wr(0, 16'hCCCC, 1, acc);
    chk(active == 1'b1, "start R4", int'(active), 1);
    waitw(40);

    wr(0, 16'h5555, 1, acc);
    wr(2, 16'h0010, 1, acc);
    wr(1, 16'h0001, 1, acc);
    wr(0, 16'hAAAA, 1, acc);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      waitw(1);
      if (wdg_rst) seen++;
    end
    chk(seen == RSTC, "expiry pulse R3", seen, RSTC);

    dbg_halt = 1;
    wr(2, 16'h0003, 1, acc);
    wr(0, 16'hAAAA, 1, acc);
    chk(count == 12'h010, "locked reload R6", int'(count), 'h10);
    wr(0, 16'h5555, 1, acc);
    wr(0, 16'h1234, 1, acc);
    wr(2, 16'h0005, 1, acc);
    wr(0, 16'hAAAA, 1, acc);
    chk(count == 12'h010, "relocked reload R6", int'(count), 'h10);
    wr(3, 16'h0007, 1, acc);

    wr(0, 16'h5555, 0, acc);
    wr(2, 16'h0020, 0, acc);
    chk(acc == 1'b0, "write while busy dropped R9", int'(acc), 0);
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    waitw(1);
    wr(0, 16'hAAAA, 1, acc);
    chk(count == 12'h010, "dropped reload R9", int'(count), 'h10);

    c0 = int'(count);
    waitw(40);
    chk(int'(count) == c0, "halt freeze R8", int'(count), c0);
    dbg_halt = 0;

    wr(0, 16'h0000, 1, acc);
    waitw(3);
    chk(active == 1'b1, "no software stop R4", int'(active), 1);

    dbg_halt = 1;
    wr(0, 16'h5555, 1, acc);
    wr(1, 16'h0007, 1, acc);
    wr(0, 16'hAAAA, 1, acc);
    dbg_halt = 0;
    waitw(255);
    chk(count == 12'h010, "div256 before tick R2", int'(count), 'h10);
    waitw(1);
    chk(count == 12'h00F, "div256 tick R2", int'(count), 'hF);

    wr(0, 16'h5555, 1, acc);
    wr(2, 16'h0001, 1, acc);
    wr(1, 16'h0000, 1, acc);
    wr(0, 16'hAAAA, 1, acc);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      waitw(1);
      if (wdg_rst) seen++;
    end
    chk(seen > RSTC, "short timeout repeats R3", seen, 4 * RSTC);

    @(negedge wclk); #1;
    rst_n = 0; hw_start = 1;
    #50 rst_n = 1;
    waitw(2);
    chk(active == 1'b1, "hardware start R7", int'(active), 1);
    waitw(10);
    chk(count < 12'hFFF, "hardware start counts R7", int'(count), 'hFFE);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog timeout R9 actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule